// File: doc/BRIEF.md
# Dual-Port Byte-Lane Synchronous RAM

This block is a true dual-port synchronous static memory of 18-bit words. The words are split into two 9-bit byte lanes. Both ports can read or write any location on the same clock. Each port has:

- a pair of chip selects;
- an active-low write strobe;
- an active-low select for each lane;
- an output enable that acts without a clock;
- its own address counter, which can load, advance, hold or clear.

A static mode input on each port chooses how reads are returned. In flow-through mode, read data appears right after the edge that samples the read. In pipelined mode, it appears one edge later. The output drivers of a pad ring are modelled by an 18-bit data bus plus one valid flag per lane. A lane that is not driven reads as zero and has its flag low.

Both ports run from one clock in this model, so that a same-cycle write conflict has a defined winner. The depth is 2^ADDR_W words. The default is 256 words, and the parameter reaches the full 32K-word size at 15.

Top module: `dpr_bytelane_ram`

## Requirements
- R1: A synchronous reset clears every lane valid flag and both address counters. A write issued after reset with neither load nor advance goes to address 0.
- R2: A port is selected only when cs0_n is 0 and cs1 is 1. On any other combination, that edge writes nothing, and both lane flags are low after the edge.
- R3: Lane 1 is data bits 17:9 and is gated by ub_n. Lane 0 is bits 8:0 and is gated by lb_n. A selected write (we_n = 0) changes only the lanes whose select is 0.
- R4: A selected read (we_n = 1) in flow-through mode (pipe = 0) raises the flag of each lane whose select is 0 right after the sampling edge, with that word's data. A lane that is not driven has its flag low and its data bits zero. A write cycle drives no lane.
- R5: In pipelined mode (pipe = 1), read data and flags come one edge later than in flow-through mode. They appear only if the port is also selected at that later edge, so after a deselect two selected edges are needed before output returns.
- R6: A deselect, or a lane select at 1, takes that lane's flag low from the very next edge.
- R7: oe_n = 1 forces both lane flags low immediately, with no clock edge, whatever the clocked state.
- R8: A word written on one port is read by the other port from the following edge onward. A read on the same edge as the write returns the previous contents.
- R9: When both ports write the same address on the same edge, each lane written by the left port takes the left data. Lanes written only by the right port take the right data.
- R10: The address used at an edge is chosen in this priority order:
  1. 0 when clr_n = 0;
  2. otherwise the external address when ld_n = 0;
  3. otherwise the previous address plus one (wrapping) when inc_n = 0;
  4. otherwise the previous address.

  The counter acts whether or not the port is selected.
- R11: With neither load nor advance, repeated reads return the same word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| l_addr | input | ADDR_W | Left external address |
| l_wdata | input | 18 | Left write data |
| l_cs0_n | input | 1 | Left chip select, active low |
| l_cs1 | input | 1 | Left chip select, active high |
| l_we_n | input | 1 | Left write strobe (0 write, 1 read) |
| l_ub_n | input | 1 | Left upper lane select, active low |
| l_lb_n | input | 1 | Left lower lane select, active low |
| l_oe_n | input | 1 | Left output enable, active low, unclocked |
| l_pipe | input | 1 | Left read mode (0 flow-through, 1 pipelined) |
| l_ld_n | input | 1 | Left counter load from l_addr, active low |
| l_inc_n | input | 1 | Left counter advance, active low |
| l_clr_n | input | 1 | Left counter clear, active low |
| l_rdata | output | 18 | Left read data, zero in lanes not driven |
| l_rvld | output | 2 | Left lane valid flags (bit 1 upper, bit 0 lower) |
| r_addr | input | ADDR_W | Right external address |
| r_wdata | input | 18 | Right write data |
| r_cs0_n | input | 1 | Right chip select, active low |
| r_cs1 | input | 1 | Right chip select, active high |
| r_we_n | input | 1 | Right write strobe (0 write, 1 read) |
| r_ub_n | input | 1 | Right upper lane select, active low |
| r_lb_n | input | 1 | Right lower lane select, active low |
| r_oe_n | input | 1 | Right output enable, active low, unclocked |
| r_pipe | input | 1 | Right read mode (0 flow-through, 1 pipelined) |
| r_ld_n | input | 1 | Right counter load from r_addr, active low |
| r_inc_n | input | 1 | Right counter advance, active low |
| r_clr_n | input | 1 | Right counter clear, active low |
| r_rdata | output | 18 | Right read data, zero in lanes not driven |
| r_rvld | output | 2 | Right lane valid flags (bit 1 upper, bit 0 lower) |

## Verification
The timing of each result is fixed:

- A flow-through read is due in the half cycle after the edge that samples it.
- A pipelined read is due one edge later and also needs a select at that edge.
- A write is visible to either port from the next edge.
- The output enable acts with no edge at all.

The bench drives inputs on the falling edge and advances a behavioural model on the rising edge. It then compares both ports against the model on the next falling edge, so every result is checked in the exact cycle it is due. The output enable is checked one time unit after it changes, between edges.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    typedef logic [LANES-1:0]  lane_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  sel;
        logic  rd;
        logic  wr;
        lane_t lanes;
    } acc_t;

    function automatic acc_t decode_acc(input logic cs0_n, input logic cs1,
                                        input logic we_n, input logic ub_n,
                                        input logic lb_n);
        acc_t a;
        a.sel   = !cs0_n && cs1;
        a.wr    = a.sel && !we_n;
        a.rd    = a.sel && we_n;
        a.lanes = ~{ub_n, lb_n};
        return a;
    endfunction

    function automatic word_t lane_bits(input lane_t m);
        word_t r;
        for (int i = 0; i < LANES; i++) begin
            r[i*LANE_W +: LANE_W] = {LANE_W{m[i]}};
        end
        return r;
    endfunction

endpackage

// File: rtl/dpr_addr_ctr.sv
module dpr_addr_ctr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              clr_n,
    input  logic              ld_n,
    input  logic              inc_n,
    output logic [ADDR_W-1:0] use_addr
);
    logic [ADDR_W-1:0] cnt_q;

    always_comb begin
        if (!clr_n)      use_addr = '0;
        else if (!ld_n)  use_addr = ext_addr;
        else if (!inc_n) use_addr = cnt_q + 1'b1;
        else             use_addr = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= use_addr;
    end
endmodule

// File: rtl/dpr_array.sv
module dpr_array
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_wr,
    input  lane_t             a_lanes,
    input  word_t             a_wdata,
    output word_t             a_q,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_wr,
    input  lane_t             b_lanes,
    input  word_t             b_wdata,
    output word_t             b_q
);
    localparam int DEPTH = 1 << ADDR_W;

    word_t mem [DEPTH];

    // Port a (left) is written after port b, so its lanes win a collision.
    always_ff @(posedge clk) begin
        a_q <= mem[a_addr];
        b_q <= mem[b_addr];
        for (int i = 0; i < LANES; i++) begin
            if (b_wr && b_lanes[i])
                mem[b_addr][i*LANE_W +: LANE_W] <= b_wdata[i*LANE_W +: LANE_W];
            if (a_wr && a_lanes[i])
                mem[a_addr][i*LANE_W +: LANE_W] <= a_wdata[i*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/dpr_rd_stage.sv
module dpr_rd_stage
    import dpr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  acc_t  acc,
    input  word_t arr_q,
    input  logic  pipe,
    input  logic  oe_n,
    output word_t rdata,
    output lane_t rvld
);
    lane_t ft_vld_q, pp_vld_q, vld_sel;
    word_t pp_dat_q, dat_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            ft_vld_q <= '0;
            pp_vld_q <= '0;
        end else begin
            ft_vld_q <= acc.rd ? acc.lanes : '0;
            pp_vld_q <= ft_vld_q & {LANES{acc.sel}};
        end
        pp_dat_q <= arr_q;
    end

    always_comb begin
        vld_sel = pipe ? pp_vld_q : ft_vld_q;
        dat_sel = pipe ? pp_dat_q : arr_q;
        rvld    = oe_n ? '0 : vld_sel;
        rdata   = dat_sel & lane_bits(rvld);
    end
endmodule

// File: rtl/dpr_bytelane_ram.sv
module dpr_bytelane_ram
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [17:0]       l_wdata,
    input  logic              l_cs0_n,
    input  logic              l_cs1,
    input  logic              l_we_n,
    input  logic              l_ub_n,
    input  logic              l_lb_n,
    input  logic              l_oe_n,
    input  logic              l_pipe,
    input  logic              l_ld_n,
    input  logic              l_inc_n,
    input  logic              l_clr_n,
    output logic [17:0]       l_rdata,
    output logic [1:0]        l_rvld,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [17:0]       r_wdata,
    input  logic              r_cs0_n,
    input  logic              r_cs1,
    input  logic              r_we_n,
    input  logic              r_ub_n,
    input  logic              r_lb_n,
    input  logic              r_oe_n,
    input  logic              r_pipe,
    input  logic              r_ld_n,
    input  logic              r_inc_n,
    input  logic              r_clr_n,
    output logic [17:0]       r_rdata,
    output logic [1:0]        r_rvld
);
    localparam int NP = 2;

    logic [ADDR_W-1:0] ext_a [NP];
    logic [ADDR_W-1:0] use_a [NP];
    logic              clr_n [NP], ld_n [NP], inc_n [NP], pipe [NP], oe_n [NP];
    acc_t              acc   [NP];
    word_t             wdat  [NP], arr_q [NP], rdat [NP];
    lane_t             rvld  [NP];

    assign ext_a[0] = l_addr;   assign ext_a[1] = r_addr;
    assign clr_n[0] = l_clr_n;  assign clr_n[1] = r_clr_n;
    assign ld_n[0]  = l_ld_n;   assign ld_n[1]  = r_ld_n;
    assign inc_n[0] = l_inc_n;  assign inc_n[1] = r_inc_n;
    assign pipe[0]  = l_pipe;   assign pipe[1]  = r_pipe;
    assign oe_n[0]  = l_oe_n;   assign oe_n[1]  = r_oe_n;
    assign wdat[0]  = l_wdata;  assign wdat[1]  = r_wdata;
    assign acc[0]   = decode_acc(l_cs0_n, l_cs1, l_we_n, l_ub_n, l_lb_n);
    assign acc[1]   = decode_acc(r_cs0_n, r_cs1, r_we_n, r_ub_n, r_lb_n);

    generate
        for (genvar p = 0; p < NP; p++) begin : g_port
            dpr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
                .clk      (clk),
                .rst      (rst),
                .ext_addr (ext_a[p]),
                .clr_n    (clr_n[p]),
                .ld_n     (ld_n[p]),
                .inc_n    (inc_n[p]),
                .use_addr (use_a[p])
            );
            dpr_rd_stage u_rd (
                .clk   (clk),
                .rst   (rst),
                .acc   (acc[p]),
                .arr_q (arr_q[p]),
                .pipe  (pipe[p]),
                .oe_n  (oe_n[p]),
                .rdata (rdat[p]),
                .rvld  (rvld[p])
            );
        end
    endgenerate

    dpr_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk     (clk),
        .a_addr  (use_a[0]),
        .a_wr    (acc[0].wr),
        .a_lanes (acc[0].lanes),
        .a_wdata (wdat[0]),
        .a_q     (arr_q[0]),
        .b_addr  (use_a[1]),
        .b_wr    (acc[1].wr),
        .b_lanes (acc[1].lanes),
        .b_wdata (wdat[1]),
        .b_q     (arr_q[1])
    );

    assign l_rdata = rdat[0];
    assign l_rvld  = rvld[0];
    assign r_rdata = rdat[1];
    assign r_rvld  = rvld[1];
endmodule

// File: rtl/dpr_bytelane_ram_chk.sv
module dpr_bytelane_ram_chk (
    input logic        clk,
    input logic        rst,
    input logic        l_cs0_n,
    input logic        l_cs1,
    input logic        l_we_n,
    input logic        l_ub_n,
    input logic        l_oe_n,
    input logic        l_pipe,
    input logic [17:0] l_rdata,
    input logic [1:0]  l_rvld,
    input logic        r_cs0_n,
    input logic        r_cs1,
    input logic        r_we_n,
    input logic        r_oe_n,
    input logic        r_pipe,
    input logic [1:0]  r_rvld
);
    // R2
    l_desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(!l_cs0_n && l_cs1) |=> (l_rvld == 2'b00));
    // R2
    r_desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(!r_cs0_n && r_cs1) |=> (r_rvld == 2'b00));
    // R7
    l_oe_off_chk: assert property (@(posedge clk) disable iff (rst)
        l_oe_n |-> (l_rvld == 2'b00));
    // R7
    r_oe_off_chk: assert property (@(posedge clk) disable iff (rst)
        r_oe_n |-> (r_rvld == 2'b00));
    // R4
    l_wr_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (!l_cs0_n && l_cs1 && !l_we_n) |=> (l_pipe || l_rvld == 2'b00));
    // R5
    r_pipe_wr_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (!r_cs0_n && r_cs1 && !r_we_n) |=> ##1 (!r_pipe || r_rvld == 2'b00));
    // R6
    l_lane_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!l_cs0_n && l_cs1 && l_we_n && l_ub_n) |=> (l_pipe || !l_rvld[1]));
    // R4
    l_undriven_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !l_rvld[1] |-> (l_rdata[17:9] == 9'd0));
endmodule

bind dpr_bytelane_ram dpr_bytelane_ram_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .l_cs0_n (l_cs0_n),
    .l_cs1   (l_cs1),
    .l_we_n  (l_we_n),
    .l_ub_n  (l_ub_n),
    .l_oe_n  (l_oe_n),
    .l_pipe  (l_pipe),
    .l_rdata (l_rdata),
    .l_rvld  (l_rvld),
    .r_cs0_n (r_cs0_n),
    .r_cs1   (r_cs1),
    .r_we_n  (r_we_n),
    .r_oe_n  (r_oe_n),
    .r_pipe  (r_pipe),
    .r_rvld  (r_rvld)
);

// File: tb/dpr_bytelane_ram_bench.sv
module dpr_bytelane_ram_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] addr [2];
    logic [17:0]   wd   [2];
    logic          cs0_n [2], cs1 [2], we_n [2], ub_n [2], lb_n [2];
    logic          oe_n [2], pipe [2], ld_n [2], inc_n [2], clr_n [2];
    logic [17:0]   rd [2];
    logic [1:0]    rv [2];

    int    tests = 0;
    int    fails = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    dpr_bytelane_ram #(.ADDR_W(AW)) u_dpr_bytelane_ram (
        .clk(clk), .rst(rst),
        .l_addr(addr[0]), .l_wdata(wd[0]), .l_cs0_n(cs0_n[0]), .l_cs1(cs1[0]),
        .l_we_n(we_n[0]), .l_ub_n(ub_n[0]), .l_lb_n(lb_n[0]), .l_oe_n(oe_n[0]),
        .l_pipe(pipe[0]), .l_ld_n(ld_n[0]), .l_inc_n(inc_n[0]), .l_clr_n(clr_n[0]),
        .l_rdata(rd[0]), .l_rvld(rv[0]),
        .r_addr(addr[1]), .r_wdata(wd[1]), .r_cs0_n(cs0_n[1]), .r_cs1(cs1[1]),
        .r_we_n(we_n[1]), .r_ub_n(ub_n[1]), .r_lb_n(lb_n[1]), .r_oe_n(oe_n[1]),
        .r_pipe(pipe[1]), .r_ld_n(ld_n[1]), .r_inc_n(inc_n[1]), .r_clr_n(clr_n[1]),
        .r_rdata(rd[1]), .r_rvld(rv[1])
    );

    // Behavioural reference model
    logic [17:0] mm [int];
    int          cnt [2];
    logic [1:0]  m_ftv [2], m_pv [2];
    logic [17:0] m_ftd [2], m_pd [2];

    always @(posedge clk) begin
        int          use_a [2];
        logic [17:0] rdv [2];
        if (rst) begin
            for (int p = 0; p < 2; p++) begin
                cnt[p] = 0; m_ftv[p] = 2'b00; m_pv[p] = 2'b00;
            end
        end else begin
            for (int p = 0; p < 2; p++) begin
                if (!clr_n[p])      use_a[p] = 0;
                else if (!ld_n[p])  use_a[p] = int'(addr[p]);
                else if (!inc_n[p]) use_a[p] = (cnt[p] + 1) % (1 << AW);
                else                use_a[p] = cnt[p];
                rdv[p] = mm.exists(use_a[p]) ? mm[use_a[p]] : 18'd0;
            end
            for (int p = 0; p < 2; p++) begin
                bit s;
                s = !cs0_n[p] && cs1[p];
                m_pv[p]  = m_ftv[p] & {2{s}};
                m_pd[p]  = m_ftd[p];
                m_ftv[p] = (s && we_n[p]) ? ~{ub_n[p], lb_n[p]} : 2'b00;
                m_ftd[p] = rdv[p];
                cnt[p]   = use_a[p];
            end
            for (int p = 1; p >= 0; p--) begin
                if (!cs0_n[p] && cs1[p] && !we_n[p]) begin
                    logic [17:0] w;
                    w = mm.exists(use_a[p]) ? mm[use_a[p]] : 18'd0;
                    if (!ub_n[p]) w[17:9] = wd[p][17:9];
                    if (!lb_n[p]) w[8:0]  = wd[p][8:0];
                    mm[use_a[p]] = w;
                end
            end
        end
    end

    task automatic check_ports();
        for (int p = 0; p < 2; p++) begin
            logic [1:0]  ev;
            logic [17:0] ed;
            ev = (pipe[p] ? m_pv[p] : m_ftv[p]) & (oe_n[p] ? 2'b00 : 2'b11);
            ed = pipe[p] ? m_pd[p] : m_ftd[p];
            ed = {ev[1] ? ed[17:9] : 9'd0, ev[0] ? ed[8:0] : 9'd0};
            tests++;
            if (rv[p] !== ev || rd[p] !== ed) begin
                fails++;
                $display("FAIL %s port %0d: rvld=%b rdata=%h expected rvld=%b rdata=%h",
                         cur_req, p, rv[p], rd[p], ev, ed);
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        check_ports();
    endtask

    task automatic drv(input int p, input logic c0n, input logic c1, input logic wen,
                       input logic ldn, input logic incn, input logic [AW-1:0] a,
                       input logic [17:0] d, input logic [1:0] lanes_n);
        cs0_n[p] = c0n; cs1[p] = c1; we_n[p] = wen; ld_n[p] = ldn; inc_n[p] = incn;
        clr_n[p] = 1'b1; addr[p] = a; wd[p] = d; ub_n[p] = lanes_n[1]; lb_n[p] = lanes_n[0];
    endtask

    task automatic idle(input int p);
        drv(p, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0, 2'b00);
    endtask

    task automatic expect_vld(input int p, input logic [1:0] ev, input string tag);
        tests++;
        if (rv[p] !== ev) begin
            fails++;
            $display("FAIL %s port %0d: rvld=%b expected rvld=%b", tag, p, rv[p], ev);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            idle(p); oe_n[p] = 1'b0;
        end
        pipe[0] = 1'b0; pipe[1] = 1'b1;
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        // R1: flags low after reset
        cur_req = "R1";
        expect_vld(0, 2'b00, "R1");
        expect_vld(1, 2'b00, "R1");
        // R1: counter at 0 -> hold write lands at 0, advance to 1
        drv(0, 0, 1, 0, 1, 1, 8'hFF, 18'h0A5A5, 2'b00); step();
        drv(0, 0, 1, 0, 1, 0, 8'hFF, 18'h01111, 2'b00); step();
        idle(0); step();
        drv(0, 0, 1, 1, 0, 1, 8'd0, '0, 2'b00); step();
        drv(0, 0, 1, 1, 1, 0, 8'd0, '0, 2'b00); step();
        idle(0); step();

        // R10: burst write via load then advance
        cur_req = "R10";
        drv(0, 0, 1, 0, 0, 1, 8'd16, 18'h10000, 2'b00); step();
        for (int i = 1; i < 8; i++) begin
            drv(0, 0, 1, 0, 1, 0, 8'd0, 18'h10000 + 18'(i * 18'h0111), 2'b00); step();
        end
        // R4: flow-through read burst
        cur_req = "R4";
        drv(0, 0, 1, 1, 0, 1, 8'd16, '0, 2'b00); step();
        for (int i = 1; i < 8; i++) begin
            drv(0, 0, 1, 1, 1, 0, 8'd0, '0, 2'b00); step();
        end
        idle(0); step();

        // R11: hold re-reads the same word
        cur_req = "R11";
        drv(0, 0, 1, 1, 0, 1, 8'd18, '0, 2'b00); step();
        drv(0, 0, 1, 1, 1, 1, 8'd99, '0, 2'b00); step(); step(); step();

        // R7: output enable acts between edges
        oe_n[0] = 1'b1; #1;
        expect_vld(0, 2'b00, "R7");
        oe_n[0] = 1'b0; #1;
        expect_vld(0, 2'b11, "R7");
        idle(0); step();

        // R3: lane writes, then reads; R6 lane off
        cur_req = "R3";
        drv(0, 0, 1, 0, 0, 1, 8'd17, 18'h3FFFF, 2'b01); step();
        drv(0, 0, 1, 0, 0, 1, 8'd18, 18'h3FFFF, 2'b10); step();
        drv(0, 0, 1, 1, 0, 1, 8'd17, '0, 2'b00); step();
        drv(0, 0, 1, 1, 0, 1, 8'd18, '0, 2'b00); step();
        cur_req = "R6";
        drv(0, 0, 1, 1, 0, 1, 8'd19, '0, 2'b01); step();
        drv(0, 0, 1, 1, 0, 1, 8'd19, '0, 2'b10); step();
        idle(0); step();

        // R2: writes with chip select off are dropped
        cur_req = "R2";
        drv(0, 0, 0, 0, 0, 1, 8'd16, 18'h00000, 2'b00); step();
        drv(0, 1, 1, 0, 0, 1, 8'd20, 18'h00000, 2'b00); step();
        drv(0, 1, 0, 1, 0, 1, 8'd21, '0, 2'b00); step();
        drv(0, 0, 1, 1, 0, 1, 8'd16, '0, 2'b00); step();
        drv(0, 0, 1, 1, 0, 1, 8'd20, '0, 2'b00); step();
        idle(0); step();

        // R5: right port pipelined burst read of left-written data (R8)
        cur_req = "R5";
        drv(1, 0, 1, 1, 0, 1, 8'd16, '0, 2'b00); step();
        for (int i = 1; i < 8; i++) begin
            drv(1, 0, 1, 1, 1, 0, 8'd0, '0, 2'b00); step();
        end
        idle(1); step(); step();
        // R5: reselect after deselect needs two selected edges
        drv(1, 0, 1, 1, 0, 1, 8'd20, '0, 2'b00); step();
        idle(1); step();
        drv(1, 0, 1, 1, 1, 1, 8'd0, '0, 2'b00); step();
        expect_vld(1, 2'b00, "R5");
        step();
        expect_vld(1, 2'b11, "R5");
        idle(1); step(); step();

        // R9: same-address collision, left wins per lane
        cur_req = "R9";
        drv(0, 0, 1, 0, 0, 1, 8'd40, 18'h12345, 2'b00);
        drv(1, 0, 1, 0, 0, 1, 8'd40, 18'h0ABCD, 2'b00); step();
        drv(0, 0, 1, 0, 0, 1, 8'd41, 18'h3FE00, 2'b01);
        drv(1, 0, 1, 0, 0, 1, 8'd41, 18'h155AA, 2'b00); step();
        idle(1);
        drv(0, 0, 1, 1, 0, 1, 8'd40, '0, 2'b00); step();
        drv(0, 0, 1, 1, 0, 1, 8'd41, '0, 2'b00); step();
        idle(0); step();

        // R8: same-edge write/read across ports
        cur_req = "R8";
        pipe[1] = 1'b0;
        drv(0, 0, 1, 0, 0, 1, 8'd16, 18'h2C3C3, 2'b00);
        drv(1, 0, 1, 1, 0, 1, 8'd16, '0, 2'b00); step();
        idle(0);
        drv(1, 0, 1, 1, 1, 1, 8'd0, '0, 2'b00); step();
        idle(1); step();

        // R10: clear overrides load, then advance
        cur_req = "R10";
        cs0_n[0] = 0; cs1[0] = 1; we_n[0] = 1; ub_n[0] = 0; lb_n[0] = 0;
        clr_n[0] = 0; ld_n[0] = 0; inc_n[0] = 1; addr[0] = 8'd23; step();
        drv(0, 0, 1, 1, 1, 0, 8'd0, '0, 2'b00); step();
        // R10: counter advances while deselected
        drv(0, 1, 1, 1, 0, 1, 8'd16, '0, 2'b00); step();
        drv(0, 1, 1, 1, 1, 0, 8'd0, '0, 2'b00); step();
        drv(0, 0, 1, 1, 1, 1, 8'd0, '0, 2'b00); step();
        // R10: wrap from top address
        drv(0, 0, 1, 0, 0, 1, 8'd255, 18'h07777, 2'b00); step();
        drv(0, 0, 1, 1, 1, 0, 8'd0, '0, 2'b00); step();
        idle(0); step();

        // R5: left switched to pipelined mode
        cur_req = "R5";
        pipe[0] = 1'b1; step();
        drv(0, 0, 1, 1, 0, 1, 8'd16, '0, 2'b00); step();
        for (int i = 1; i < 4; i++) begin
            drv(0, 0, 1, 1, 1, 0, 8'd0, '0, 2'b00); step();
        end
        idle(0); step(); step();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule